// File: doc/BRIEF.md
# Charger Configuration Register Target on a Two-Wire Serial Bus

This block is a target on a two-wire serial bus (I2C) that holds the settings of a single-cell battery charger. A host changes them over the bus. The two bus lines arrive as raw levels and are oversampled by the system clock. Each line passes through a two-flop synchroniser and a three-tap majority vote before the block looks for edges. A protocol engine then decodes START, repeated START and STOP conditions. It compares the first byte with the fixed 7-bit address 0x47 and carries out single-register writes and reads. Writes use R/W = 0 and reads use R/W = 1. A read is a register-pointer write, then a repeated START, then a read of one byte.

Three 8-bit registers hold the configuration:
- **Pointer 0x00:** the regulation-voltage select and the mains-adaptor current code.
- **Pointer 0x01:** a 2-bit end-of-charge select, plus two read-only status bits taken live from inputs.
- **Pointer 0x02:** the USB current code.

The registers sit on their own retention reset, so a reset of the protocol engine leaves them untouched. The block decodes the register contents into setpoints: two currents in mA, the voltage select, and the end-of-charge threshold in twentieths of the capacity C.

The engine states are:
- **ST_IDLE:** the bus is free.
- **ST_ADDR:** eight bits of address and R/W are shifted in.
- **ST_ADDR_ACK:** the address is acknowledged.
- **ST_REG:** the pointer byte is shifted in.
- **ST_REG_ACK:** the pointer byte is acknowledged.
- **ST_WDATA:** the data byte is shifted in.
- **ST_WDATA_ACK:** the data byte is acknowledged.
- **ST_RDATA:** the register is shifted out, MSB first.
- **ST_RMACK:** the host's acknowledge bit passes.
- **ST_WAIT:** the rest of the transfer is ignored until a START or STOP.

The transitions are:
- Any START moves to ST_ADDR, from any state.
- Any STOP moves to ST_IDLE, from any state.
- ST_ADDR moves to ST_ADDR_ACK on a match, or to ST_WAIT otherwise, at the SCL fall after the eighth bit.
- ST_ADDR_ACK moves to ST_RDATA for a read or to ST_REG for a write, at the SCL fall that ends the acknowledge bit.
- ST_REG moves to ST_REG_ACK after eight bits.
- ST_REG_ACK moves to ST_WDATA.
- ST_WDATA moves to ST_WDATA_ACK after eight bits; the register is written at this point.
- ST_WDATA_ACK moves to ST_WAIT.
- ST_RDATA moves to ST_RMACK after its eighth SCL fall.
- ST_RMACK moves to ST_WAIT.

Top module: `chg_cfg_i2c`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 0x47. For any other address it leaves SDA released for the acknowledge bit and ignores the rest of the transfer, so no register changes.
- R2: A write transfer is: address with R/W = 0, then a pointer byte, then a data byte. Each of the three bytes is acknowledged, and the data byte is stored in the register the pointer selects.
- R3: A read is: pointer write, repeated START, address with R/W = 1, then one byte. The byte is the selected register, MSB first. Unused bits read as 0, and pointers above 0x02 read as 0x00.
- R4: While the retention reset is asserted, the registers take their defaults: 0x00 = 0x08, 0x01 = 0x01 with status bits 0, and 0x02 = 0x08.
- R5: In register 0x00, bit 4 is the voltage select and bits 3:0 are the mains-adaptor current code. Output vreg_42 follows bit 4: 1 means 4.2 V and 0 means 4.1 V.
- R6: A current code n from 0 to 13 gives 100 + 50·n mA on ac_ma (from 0x00[3:0]) or usb_ma (from 0x02[3:0]). Codes 14 and 15 give 750 mA.
- R7: In register 0x01, bit 3 reads the end-of-charge status input and bit 2 reads the charging status input. Writes do not change these bits. Bits 1:0 hold the end-of-charge select.
- R8: eoc_twentieths is 2 for select 01, 3 for select 10, 4 for select 11 and 2 for select 00.
- R9: Writes to pointers above 0x02 are acknowledged and change no register.
- R10: Asserting the protocol reset alone leaves all register contents and setpoints unchanged.
- R11: A STOP after the pointer byte and before the data byte ends the transfer with no register change. The next transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset of the line filters and protocol engine |
| ret_rst_n | input | 1 | Active-low retention reset of the register file |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| eoc_stat_in | input | 1 | End-of-charge status, read at 0x01 bit 3 |
| chg_stat_in | input | 1 | Charging status, read at 0x01 bit 2 |
| vreg_42 | output | 1 | Regulation voltage select, 1 = 4.2 V |
| ac_ma | output | 10 | Mains-adaptor charge current setpoint in mA |
| usb_ma | output | 10 | USB charge current setpoint in mA |
| eoc_twentieths | output | 3 | End-of-charge threshold in units of 0.05C |

## Verification
A bus edge takes about six system cycles to reach the engine: two synchroniser flops, the majority vote, the filtered register, and then the registered sda_oe. The acknowledge drive and each read-data bit therefore appear about seven cycles after the SCL fall that starts them. The bench drives every bus phase for ten system cycles and samples SDA in the middle of the SCL-high phase, twenty or more cycles after that fall. Register writes happen one cycle after the SCL fall that ends the eighth data bit, and the setpoints follow through combinational decoding. The bench reads the setpoints only after the STOP plus a further bus phase, well past that point.

// File: rtl/chg_cfg_pkg.sv
package chg_cfg_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 4;

    localparam logic [REG_W-1:0] PTR_AC   = 8'h00;
    localparam logic [REG_W-1:0] PTR_STAT = 8'h01;
    localparam logic [REG_W-1:0] PTR_USB  = 8'h02;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RMACK,
        ST_WAIT
    } i2c_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MAJ_TAPS    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_q,
    output logic line_rise,
    output logic line_fall
);
    localparam int HALF = MAJ_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [MAJ_TAPS-1:0]    tap_q;
    logic                   prev_q;
    logic                   vote;

    // Synchroniser chain; the bus idles high, so reset to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            tap_q  <= '1;
            line_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            tap_q  <= {tap_q[MAJ_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            line_q <= vote;
            prev_q <= line_q;
        end
    end

    always_comb begin
        vote = ($countones(tap_q) > HALF);
    end

    assign line_rise = line_q & ~prev_q;
    assign line_fall = ~line_q & prev_q;

endmodule

// File: rtl/chg_i2c_engine.sv
module chg_i2c_engine
    import chg_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h47
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_q,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_q,
    input  logic             sda_rise,
    input  logic             sda_fall,
    input  logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] ptr,
    output logic             sda_oe,
    output logic             wr_stb,
    output logic [REG_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(REG_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REG_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REG_W - 1);

    i2c_state_e       state, state_d;
    logic [REG_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             rw_q;
    logic             start_ev, stop_ev;
    logic             byte_done;
    logic             addr_hit;
    logic             drive_d;
    logic             wr_now;

    assign start_ev  = scl_q & sda_fall;
    assign stop_ev   = scl_q & sda_rise;
    assign byte_done = scl_fall && (cnt == CNT_FULL);
    assign addr_hit  = (shreg[REG_W-1:1] == DEV_ADDR);
    assign wr_now    = (state == ST_WDATA) && byte_done;

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:      state_d = ST_IDLE;
            ST_ADDR:      if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_WAIT;
            ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_REG;
            ST_REG:       if (byte_done) state_d = ST_REG_ACK;
            ST_REG_ACK:   if (scl_fall) state_d = ST_WDATA;
            ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall) state_d = ST_WAIT;
            ST_RDATA:     if (scl_fall && cnt == CNT_LAST) state_d = ST_RMACK;
            ST_RMACK:     if (scl_fall) state_d = ST_WAIT;
            ST_WAIT:      state_d = ST_WAIT;
            default:      state_d = ST_IDLE;
        endcase
        if (stop_ev) state_d = ST_IDLE;
        if (start_ev) state_d = ST_ADDR;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Shift register, bit counter, pointer, direction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            rw_q  <= 1'b0;
            ptr   <= '0;
        end else if (start_ev) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[REG_W-2:0], sda_q};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) rw_q <= shreg[0];
                        if (state == ST_REG)  ptr  <= shreg;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) begin
                        shreg <= rd_data;
                        cnt   <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg <= {shreg[REG_W-2:0], 1'b0};
                        cnt   <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Value the SDA driver takes at the next edge
    always_comb begin
        drive_d = 1'b0;
        unique case (state_d)
            ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: drive_d = 1'b1;
            ST_RDATA: begin
                if (state != ST_RDATA)  drive_d = ~rd_data[REG_W-1];
                else if (scl_fall)      drive_d = ~shreg[REG_W-2];
                else                    drive_d = ~shreg[REG_W-1];
            end
            default: drive_d = 1'b0;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_data <= '0;
        end else begin
            sda_oe <= drive_d;
            wr_stb <= wr_now;
            if (wr_now) wr_data <= shreg;
        end
    end

    // R1: the target only starts pulling SDA low while SCL is low.
    a_r1_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);

    // R2: a register write is issued only while the data byte is acknowledged.
    a_r2_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (state == ST_WDATA_ACK));

    // R11: after a STOP the bus is released.
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/chg_reg_file.sv
module chg_reg_file
    import chg_cfg_pkg::*;
#(
    parameter logic [4:0]        DEF_AC  = 5'b0_1000,
    parameter logic [1:0]        DEF_EOC = 2'b01,
    parameter logic [CODE_W-1:0] DEF_USB = 4'b1000
) (
    input  logic              clk,
    input  logic              ret_rst_n,
    input  logic              wr_stb,
    input  logic [REG_W-1:0]  wr_ptr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [REG_W-1:0]  rd_ptr,
    input  logic              eoc_stat,
    input  logic              chg_stat,
    output logic [REG_W-1:0]  rd_data,
    output logic              vsel,
    output logic [CODE_W-1:0] ac_code,
    output logic [CODE_W-1:0] usb_code,
    output logic [1:0]        eoc_sel
);
    logic [4:0]        ac_reg;
    logic [1:0]        eoc_reg;
    logic [CODE_W-1:0] usb_reg;

    always_ff @(posedge clk or negedge ret_rst_n) begin
        if (!ret_rst_n) begin
            ac_reg  <= DEF_AC;
            eoc_reg <= DEF_EOC;
            usb_reg <= DEF_USB;
        end else if (wr_stb) begin
            case (wr_ptr)
                PTR_AC:   ac_reg  <= wr_data[4:0];
                PTR_STAT: eoc_reg <= wr_data[1:0];
                PTR_USB:  usb_reg <= wr_data[CODE_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_ptr)
            PTR_AC:   rd_data = {3'b000, ac_reg};
            PTR_STAT: rd_data = {4'b0000, eoc_stat, chg_stat, eoc_reg};
            PTR_USB:  rd_data = {{(REG_W-CODE_W){1'b0}}, usb_reg};
            default:  rd_data = '0;
        endcase
    end

    assign vsel     = ac_reg[4];
    assign ac_code  = ac_reg[CODE_W-1:0];
    assign usb_code = usb_reg;
    assign eoc_sel  = eoc_reg;

    // R9: pointers above 0x02 leave every register as it was.
    a_r9_high_ptr_ignored: assert property (@(posedge clk) disable iff (!ret_rst_n)
        (wr_stb && wr_ptr > PTR_USB) |=> ($stable(ac_reg) && $stable(eoc_reg) && $stable(usb_reg)));

    // R7: the end-of-charge select changes only through a write to 0x01.
    a_r7_sel_only_by_write: assert property (@(posedge clk) disable iff (!ret_rst_n)
        !(wr_stb && wr_ptr == PTR_STAT) |=> $stable(eoc_sel));

    // R10: without a write strobe the mains-adaptor register is held.
    a_r10_hold_without_write: assert property (@(posedge clk) disable iff (!ret_rst_n)
        !wr_stb |=> ($stable(vsel) && $stable(ac_code)));

endmodule

// File: rtl/chg_setpoint_decode.sv
module chg_setpoint_decode
    import chg_cfg_pkg::*;
#(
    parameter int MA_W     = 10,
    parameter int MA_BASE  = 100,
    parameter int MA_STEP  = 50,
    parameter int CODE_MAX = 13,
    parameter int N_CH     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_CH-1:0][CODE_W-1:0] codes,
    input  logic [1:0]                  eoc_sel,
    output logic [N_CH-1:0][MA_W-1:0]   ma,
    output logic [2:0]                  eoc_twentieths
);
    localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(CODE_MAX);
    localparam logic [MA_W-1:0]   MA_TOP   = MA_W'(MA_BASE + MA_STEP * CODE_MAX);
    localparam logic [MA_W-1:0]   MA_LOW   = MA_W'(MA_BASE);
    localparam logic [MA_W-1:0]   MA_INC   = MA_W'(MA_STEP);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        always_comb begin
            if (codes[g] > CODE_TOP) ma[g] = MA_TOP;
            else ma[g] = MA_LOW + MA_INC * {{(MA_W-CODE_W){1'b0}}, codes[g]};
        end

        // R6: every setpoint stays inside the supported range.
        a_r6_ma_bounds: assert property (@(posedge clk) disable iff (!rst_n)
            (ma[g] >= MA_LOW) && (ma[g] <= MA_TOP));
    end

    always_comb begin
        case (eoc_sel)
            2'b10:   eoc_twentieths = 3'd3;
            2'b11:   eoc_twentieths = 3'd4;
            default: eoc_twentieths = 3'd2;
        endcase
    end

    // R8: the threshold is one of 0.10C, 0.15C, 0.20C.
    a_r8_eoc_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_twentieths >= 3'd2) && (eoc_twentieths <= 3'd4));

endmodule

// File: rtl/chg_cfg_i2c.sv
module chg_cfg_i2c
    import chg_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h47,
    parameter int         SYNC_STAGES = 2,
    parameter int         MAJ_TAPS    = 3,
    parameter int         MA_W        = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    input  logic            eoc_stat_in,
    input  logic            chg_stat_in,
    output logic            vreg_42,
    output logic [MA_W-1:0] ac_ma,
    output logic [MA_W-1:0] usb_ma,
    output logic [2:0]      eoc_twentieths
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw, lvl, rise, fall;
    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .MAJ_TAPS   (MAJ_TAPS)
        ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_in  (raw[g]),
            .line_q   (lvl[g]),
            .line_rise(rise[g]),
            .line_fall(fall[g])
        );
    end

    logic [REG_W-1:0]  rd_data, ptr, wr_data;
    logic              wr_stb;
    logic [CODE_W-1:0] ac_code, usb_code;
    logic [1:0]        eoc_sel;
    logic [1:0][MA_W-1:0] ma_pair;

    chg_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_q   (lvl[0]),
        .scl_rise(rise[0]),
        .scl_fall(fall[0]),
        .sda_q   (lvl[1]),
        .sda_rise(rise[1]),
        .sda_fall(fall[1]),
        .rd_data (rd_data),
        .ptr     (ptr),
        .sda_oe  (sda_oe),
        .wr_stb  (wr_stb),
        .wr_data (wr_data)
    );

    chg_reg_file u_regs (
        .clk      (clk),
        .ret_rst_n(ret_rst_n),
        .wr_stb   (wr_stb),
        .wr_ptr   (ptr),
        .wr_data  (wr_data),
        .rd_ptr   (ptr),
        .eoc_stat (eoc_stat_in),
        .chg_stat (chg_stat_in),
        .rd_data  (rd_data),
        .vsel     (vreg_42),
        .ac_code  (ac_code),
        .usb_code (usb_code),
        .eoc_sel  (eoc_sel)
    );

    chg_setpoint_decode #(.MA_W(MA_W)) u_dec (
        .clk           (clk),
        .rst_n         (ret_rst_n),
        .codes         ({usb_code, ac_code}),
        .eoc_sel       (eoc_sel),
        .ma            (ma_pair),
        .eoc_twentieths(eoc_twentieths)
    );

    assign ac_ma  = ma_pair[0];
    assign usb_ma = ma_pair[1];

endmodule

// File: tb/sim_chg_cfg_i2c.sv
`timescale 1ns/1ps
module sim_chg_cfg_i2c;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, ret_rst_n = 1'b0;
    logic scl = 1'b1, msda = 1'b1;
    logic eoc_st = 1'b0, chg_st = 1'b0;
    logic sda_oe, vreg_42;
    logic [9:0] ac_ma, usb_ma;
    logic [2:0] eoc_tw;
    wire  bus = msda & ~sda_oe;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chg_cfg_i2c u0 (
        .clk(clk), .rst_n(rst_n), .ret_rst_n(ret_rst_n),
        .scl_in(scl), .sda_in(bus), .sda_oe(sda_oe),
        .eoc_stat_in(eoc_st), .chg_stat_in(chg_st),
        .vreg_42(vreg_42), .ac_ma(ac_ma), .usb_ma(usb_ma),
        .eoc_twentieths(eoc_tw)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        msda = 1'b1; wq(); scl = 1'b1; wq(); msda = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bstop();
        msda = 1'b0; wq(); scl = 1'b1; wq(); msda = 1'b1; wq(); wq();
    endtask

    task automatic bbit(input logic b, output logic s);
        msda = b; wq(); scl = 1'b1; wq(); s = bus; wq(); scl = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bbit(d[i], s);
        bbit(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bbit(1'b1, s);
            d[i] = s;
        end
        bbit(1'b1, s);
    endtask

    task automatic reg_wr(input logic [7:0] p, input logic [7:0] d, output int acks);
        logic a;
        acks = 0;
        bstart();
        wbyte(8'h8E, a); acks += int'(a);
        wbyte(p, a);     acks += int'(a);
        wbyte(d, a);     acks += int'(a);
        bstop();
    endtask

    task automatic reg_rd(input logic [7:0] p, output logic [7:0] d);
        logic a;
        bstart();
        wbyte(8'h8E, a);
        wbyte(p, a);
        bstart();
        wbyte(8'h8F, a);
        rbyte(d);
        bstop();
    endtask

    function automatic int exp_ma(input int n);
        return (n > 13) ? 750 : 100 + 50 * n;
    endfunction

    initial begin
        int acks;
        logic [7:0] d;
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1; ret_rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 defaults, at the outputs and over the bus
        chk("R4 ac_ma reset", int'(ac_ma), 500);
        chk("R4 usb_ma reset", int'(usb_ma), 500);
        chk("R4 vreg reset", int'(vreg_42), 0);
        chk("R4 eoc reset", int'(eoc_tw), 2);
        chk("R4 sda released", int'(sda_oe), 0);
        reg_rd(8'h00, d); chk("R4 R3 read 0x00", int'(d), 8'h08);
        reg_rd(8'h01, d); chk("R4 R3 read 0x01", int'(d), 8'h01);
        reg_rd(8'h02, d); chk("R4 R3 read 0x02", int'(d), 8'h08);

        // R5 R6 R2: sweep the mains-adaptor code with varied voltage select
        for (int i = 0; i < 16; i++) begin
            int v = (i % 3 == 0) ? 1 : 0;
            reg_wr(8'h00, {3'b111, v[0], i[3:0]}, acks);
            chk("R2 write acks", acks, 3);
            chk("R6 ac_ma", int'(ac_ma), exp_ma(i));
            chk("R5 vreg_42", int'(vreg_42), v);
            reg_rd(8'h00, d);
            chk("R3 R5 readback 0x00", int'(d), v * 16 + i);
        end

        // R6: USB code sweep
        for (int i = 0; i < 16; i++) begin
            reg_wr(8'h02, {4'b1010, i[3:0]}, acks);
            chk("R6 usb_ma", int'(usb_ma), exp_ma(i));
            if (i % 5 == 0) begin
                reg_rd(8'h02, d);
                chk("R3 readback 0x02", int'(d), i);
            end
        end

        // R8 R7: select sweep; upper bits written as 1 do not stick
        for (int i = 0; i < 4; i++) begin
            reg_wr(8'h01, {6'b111111, i[1:0]}, acks);
            chk("R8 eoc_twentieths", int'(eoc_tw), (i == 3) ? 4 : (i == 2) ? 3 : 2);
            eoc_st = i[0]; chg_st = i[1];
            repeat (4) @(negedge clk);
            reg_rd(8'h01, d);
            chk("R7 readback 0x01", int'(d), i[0] * 8 + i[1] * 4 + i);
        end
        eoc_st = 1'b0; chg_st = 1'b0;

        // R1: a wrong address is not acknowledged and writes nothing
        reg_wr(8'h00, 8'h05, acks);   // 0x00 now holds code 5, vsel 0
        bstart();
        wbyte(8'h90, a);
        chk("R1 wrong address nack", int'(a), 0);
        wbyte(8'h00, a); wbyte(8'h0C, a);
        bstop();
        chk("R1 no change after foreign write", int'(ac_ma), exp_ma(5));
        bstart(); wbyte(8'h8E, a); bstop();
        chk("R1 own address ack", int'(a), 1);

        // R9: pointer 0x03 acknowledged and ignored; reads as zero
        reg_wr(8'h03, 8'hFF, acks);
        chk("R9 acks on high pointer", acks, 3);
        chk("R9 ac unchanged", int'(ac_ma), exp_ma(5));
        chk("R9 usb unchanged", int'(usb_ma), 750);
        chk("R9 eoc unchanged", int'(eoc_tw), 4);
        reg_rd(8'h03, d);
        chk("R3 R9 read 0x03", int'(d), 0);

        // R11: STOP before the data byte
        bstart(); wbyte(8'h8E, a); wbyte(8'h00, a); bstop();
        chk("R11 aborted write no change", int'(ac_ma), exp_ma(5));
        reg_rd(8'h00, d);
        chk("R11 following read", int'(d), 5);

        // R10: protocol reset keeps the registers
        rst_n = 1'b0; repeat (5) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
        chk("R10 ac kept", int'(ac_ma), exp_ma(5));
        chk("R10 usb kept", int'(usb_ma), 750);
        chk("R10 eoc kept", int'(eoc_tw), 4);

        // R4: retention reset restores defaults
        ret_rst_n = 1'b0; repeat (5) @(negedge clk); ret_rst_n = 1'b1; repeat (5) @(negedge clk);
        chk("R4 ac default again", int'(ac_ma), 500);
        chk("R4 usb default again", int'(usb_ma), 500);
        chk("R4 eoc default again", int'(eoc_tw), 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule